// File: doc/BRIEF.md
# Serial Bus Receive Buffer and Overrun Manager

This block sits between a bit-level serial bus link layer and the host side of a bus controller. The link layer hands over each received byte with a one-cycle `byte_valid` strobe, and later gives a one-cycle `ack_slot` strobe at the acknowledge bit of that byte. The block holds the byte in a one-deep data register and signals the host with a data-request pulse. It tracks the transfer-slot and message-byte counters of the frame, and raises frame-end and communication-error pulses.

A byte that arrives while the register still holds an unread byte is an overrun. The response depends on the mode latched at frame start. In unicast frames the byte is refused: a NACK is returned in its acknowledge slot so the sender repeats it, and only the slot counter moves. In broadcast frames reception stops: the register is frozen, an error pulse is raised, and the overrun stays until a byte arrives after the host has read the register. In transmit frames a pending overrun blocks the data requests for the second and later bytes, and each such byte is flagged as an underrun.

Top module: `sbrx_top`

## Requirements
- R1: A byte accepted while receiving is stored. `rd_data` shows it and `irq_data_req` is high for exactly one cycle, both in the cycle after the clock edge that sampled `byte_valid`.
- R2: A byte that arrives in an active receive frame while the register is full, with no `host_rd` in that cycle, sets `ovr_flag` and leaves `rd_data` unchanged. No data request is raised for it.
- R3: Outside broadcast frames, `ovr_flag` is cleared only by `host_rd` or by reset. It stays set through the end of the frame when no read occurs.
- R4: In a unicast frame, `ack_n` is 1 during the next `ack_slot` after a refused byte and 0 during the `ack_slot` after an accepted byte. `ack_n` is 0 when `ack_slot` is low.
- R5: `frame_start` loads `slot_left` with SLOT_MAX (32) and `msg_left` with `msg_len`. An accepted byte decrements both counters; a refused byte decrements only `slot_left`.
- R6: `irq_frame_end` pulses for one cycle when `msg_left` reaches 0 or `slot_left` reaches 0, and this ends the frame. Bytes that arrive outside an active frame are ignored.
- R7: In a broadcast frame, an overrun pulses `irq_comm_err` and stops reception. No store and no data request occur, `rx_status` stays 1, and later bytes move no counter and raise no interrupt.
- R8: In a broadcast frame, a byte that arrives after the register has been read clears `ovr_flag` and is not stored.
- R9: When `host_rd` and `byte_valid` occur in the same cycle, the read counts as first. The new byte is stored with a data request, and no overrun is flagged.
- R10: In a transmit frame, the first `tx_need` always gives a data request. A later `tx_need` gives a data request only if `ovr_flag` is 0. Otherwise it sets `udr_flag` and pulses `irq_comm_err` instead.
- R11: `frame_bcast` (1 = broadcast) and `frame_tx` (1 = transmit) are sampled at `frame_start`. `rx_status` is set by a receive frame start and cleared by a normal frame end or by a transmit frame start. `udr_flag` is cleared by any frame start.
- R12: After reset, every flag, interrupt, counter, `ack_n` and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe that opens a frame |
| frame_bcast | input | 1 | Broadcast mode, sampled at frame_start |
| frame_tx | input | 1 | Transmit direction, sampled at frame_start |
| msg_len | input | CNT_W (6) | Message byte count loaded at frame_start |
| byte_valid | input | 1 | Link layer has completed a byte |
| byte_data | input | DATA_W (8) | Received byte |
| ack_slot | input | 1 | Acknowledge bit strobe |
| ack_n | output | 1 | 1 = NACK during ack_slot |
| tx_need | input | 1 | Link layer needs the next transmit byte |
| host_rd | input | 1 | Host read of the data register |
| rd_data | output | DATA_W (8) | Data register contents |
| irq_data_req | output | 1 | Data-request pulse |
| irq_frame_end | output | 1 | Frame-end pulse |
| irq_comm_err | output | 1 | Communication-error pulse |
| ovr_flag | output | 1 | Overrun flag |
| udr_flag | output | 1 | Underrun flag |
| rx_status | output | 1 | Receive-in-progress status |
| slot_left | output | CNT_W (6) | Transfer slots remaining |
| msg_left | output | CNT_W (6) | Message bytes remaining |

## Verification
Every registered result (stored data, flags, counters and the three interrupt pulses) is due in the single cycle that follows the rising edge that sampled `byte_valid`, `tx_need`, `host_rd` or `frame_start`. `ack_n` is combinational from `ack_slot` within its own cycle. The bench drives each strobe on a falling edge, lets exactly one rising edge pass, and reads the results on the next falling edge. At that point a pulse is high for its only cycle. `ack_n` is read shortly after `ack_slot` is raised, before the rising edge that ends the slot.

// File: rtl/sbrx_pkg.sv
package sbrx_pkg;
   typedef enum logic {CAST_UNI = 1'b0, CAST_ALL = 1'b1} cast_e;
   typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;

   // classification of one incoming byte
   typedef struct packed {
      logic accept;   // stored in the data register
      logic refuse;   // unicast overrun: NACK and retransmit
      logic abort;    // broadcast overrun: halt reception
      logic rel;      // broadcast: overrun released by a byte after a read
   } rx_evt_t;
endpackage

// File: rtl/sbrx_data_reg.sv
module sbrx_data_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] q_o,
   output logic              full_o
);
   logic [DATA_W-1:0] q_q;
   logic              full_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_q    <= '0;
         full_q <= 1'b0;
      end else begin
         if (store_i) q_q <= data_i;
         // a read and a store in one cycle leave the register full
         if (store_i)   full_q <= 1'b1;
         else if (rd_i) full_q <= 1'b0;
      end
   end

   assign q_o    = q_q;
   assign full_o = full_q;

   // R9: a store is only issued into an empty register or one read this cycle
   p_store_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      store_i |-> (!full_q || rd_i));
   // R1: a stored byte leaves the register full
   p_full_after_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
      store_i |=> full_q);
endmodule

// File: rtl/sbrx_ovr_ctl.sv
module sbrx_ovr_ctl
   import sbrx_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    frame_start_i,
   input  logic    rx_en_i,
   input  cast_e   cast_i,
   input  logic    byte_valid_i,
   input  logic    full_i,
   input  logic    rd_i,
   input  logic    ack_slot_i,
   output rx_evt_t evt_o,
   output logic    ovr_o,
   output logic    halt_o,
   output logic    nack_o
);
   logic    ovr_q, halt_q, nack_q;
   logic    full_eff, live, is_uni;
   rx_evt_t evt;

   // read-before-write ordering within one cycle
   assign full_eff = full_i & ~rd_i;
   assign live     = byte_valid_i & rx_en_i;
   assign is_uni   = (cast_i == CAST_UNI);

   always_comb begin
      evt        = '0;
      evt.accept = live & ~full_eff & ~halt_q;
      evt.refuse = live &  full_eff &  is_uni;
      evt.abort  = live &  full_eff & ~is_uni & ~halt_q;
      evt.rel    = live & ~full_eff & ~is_uni & ovr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr_q  <= 1'b0;
         halt_q <= 1'b0;
         nack_q <= 1'b0;
      end else begin
         if (evt.refuse || evt.abort)   ovr_q <= 1'b1;
         else if (is_uni && rd_i)       ovr_q <= 1'b0;
         else if (evt.rel)              ovr_q <= 1'b0;

         if (frame_start_i)  halt_q <= 1'b0;
         else if (evt.abort) halt_q <= 1'b1;

         if (frame_start_i)   nack_q <= 1'b0;
         else if (live)       nack_q <= evt.refuse;
         else if (ack_slot_i) nack_q <= 1'b0;
      end
   end

   assign evt_o  = evt;
   assign ovr_o  = ovr_q;
   assign halt_o = halt_q;
   assign nack_o = nack_q;

   // R2: overrun only appears after a byte arrived
   p_ovr_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(byte_valid_i));
   // R4: a pending NACK belongs to a unicast frame
   p_nack_unicast_r4: assert property (@(posedge clk) disable iff (!rst_n)
      nack_q |-> (cast_i == CAST_UNI));
   // R7: nothing is stored while reception is halted
   p_halt_nostore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> !evt.accept);
endmodule

// File: rtl/sbrx_xfer_cnt.sv
module sbrx_xfer_cnt #(
   parameter int SLOT_MAX = 32,
   parameter int CNT_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start_i,
   input  logic [CNT_W-1:0] msg_len_i,
   input  logic             accept_i,
   input  logic             refuse_i,
   output logic [CNT_W-1:0] slot_o,
   output logic [CNT_W-1:0] msg_o,
   output logic             active_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] SLOT_INIT = CNT_W'(SLOT_MAX);
   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

   logic [CNT_W-1:0] slot_q, msg_q;
   logic             act_q, step;

   assign step   = accept_i | refuse_i;
   assign done_o = step & ((slot_q == ONE) | (accept_i & (msg_q == ONE)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         msg_q  <= '0;
         act_q  <= 1'b0;
      end else if (frame_start_i) begin
         slot_q <= SLOT_INIT;
         msg_q  <= msg_len_i;
         act_q  <= 1'b1;
      end else begin
         if (step)     slot_q <= slot_q - ONE;
         if (accept_i) msg_q  <= msg_q - ONE;
         if (done_o)   act_q  <= 1'b0;
      end
   end

   assign slot_o   = slot_q;
   assign msg_o    = msg_q;
   assign active_o = act_q;

   // R5: a refused byte leaves the message counter alone
   p_msg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (refuse_i && !frame_start_i) |=> (msg_q == $past(msg_q)));
   // R5: every counted byte uses one slot
   p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !frame_start_i) |=> (slot_q == $past(slot_q) - ONE));
   // R6: the frame closes after its end event
   p_done_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !frame_start_i) |=> !act_q);
endmodule

// File: rtl/sbrx_top.sv
module sbrx_top
   import sbrx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int SLOT_MAX   = 32,
   parameter bit NACK_LEVEL = 1'b0,
   parameter int CNT_W      = $clog2(SLOT_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_bcast,
   input  logic              frame_tx,
   input  logic [CNT_W-1:0]  msg_len,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              ack_slot,
   output logic              ack_n,
   input  logic              tx_need,
   input  logic              host_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_data_req,
   output logic              irq_frame_end,
   output logic              irq_comm_err,
   output logic              ovr_flag,
   output logic              udr_flag,
   output logic              rx_status,
   output logic [CNT_W-1:0]  slot_left,
   output logic [CNT_W-1:0]  msg_left
);
   localparam int CNT_MIN = $clog2(SLOT_MAX + 1);

   if (DATA_W < 1) begin : g_bad_width
      $error("sbrx_top: DATA_W must be at least 1");
   end
   if (SLOT_MAX < 2) begin : g_bad_slots
      $error("sbrx_top: SLOT_MAX must be at least 2");
   end
   if (CNT_W < CNT_MIN) begin : g_bad_cnt
      $error("sbrx_top: CNT_W too narrow for SLOT_MAX");
   end

   cast_e   cast_q;
   dir_e    dir_q;
   rx_evt_t evt;
   logic    full, ovr, halt, nack, active, done, rx_en;
   logic    tx_first_q, tx_live, tx_ok, tx_udr;
   logic    dreq_q, fend_q, cerr_q, udr_q, rxs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cast_q <= CAST_UNI;
         dir_q  <= DIR_RX;
      end else if (frame_start) begin
         cast_q <= frame_bcast ? CAST_ALL : CAST_UNI;
         dir_q  <= frame_tx ? DIR_TX : DIR_RX;
      end
   end

   assign rx_en = active & (dir_q == DIR_RX);

   sbrx_ovr_ctl u_ovr (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start),
      .rx_en_i       (rx_en),
      .cast_i        (cast_q),
      .byte_valid_i  (byte_valid),
      .full_i        (full),
      .rd_i          (host_rd),
      .ack_slot_i    (ack_slot),
      .evt_o         (evt),
      .ovr_o         (ovr),
      .halt_o        (halt),
      .nack_o        (nack)
   );

   sbrx_data_reg #(.DATA_W(DATA_W)) u_dreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .store_i (evt.accept),
      .data_i  (byte_data),
      .rd_i    (host_rd),
      .q_o     (rd_data),
      .full_o  (full)
   );

   sbrx_xfer_cnt #(.SLOT_MAX(SLOT_MAX), .CNT_W(CNT_W)) u_cnt (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start),
      .msg_len_i     (msg_len),
      .accept_i      (evt.accept),
      .refuse_i      (evt.refuse),
      .slot_o        (slot_left),
      .msg_o         (msg_left),
      .active_o      (active),
      .done_o        (done)
   );

   // transmit side: data requests gated by a pending overrun
   assign tx_live = tx_need & active & (dir_q == DIR_TX);
   assign tx_ok   = tx_live & (tx_first_q | ~ovr);
   assign tx_udr  = tx_live & ~tx_first_q & ovr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_first_q <= 1'b0;
         dreq_q     <= 1'b0;
         fend_q     <= 1'b0;
         cerr_q     <= 1'b0;
         udr_q      <= 1'b0;
         rxs_q      <= 1'b0;
      end else begin
         dreq_q <= evt.accept | tx_ok;
         fend_q <= done;
         cerr_q <= evt.abort | tx_udr;

         if (frame_start)  tx_first_q <= frame_tx;
         else if (tx_live) tx_first_q <= 1'b0;

         if (frame_start) udr_q <= 1'b0;
         else if (tx_udr) udr_q <= 1'b1;

         if (frame_start)        rxs_q <= ~frame_tx;
         else if (done && !halt) rxs_q <= 1'b0;
      end
   end

   // NACK presentation variant
   if (NACK_LEVEL) begin : g_ack_level
      assign ack_n = nack;
   end else begin : g_ack_slot
      assign ack_n = nack & ack_slot;
   end

   assign irq_data_req  = dreq_q;
   assign irq_frame_end = fend_q;
   assign irq_comm_err  = cerr_q;
   assign ovr_flag      = ovr;
   assign udr_flag      = udr_q;
   assign rx_status     = rxs_q;

   // R10: an underrun never comes with a data request
   p_udr_no_dreq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(udr_q) |-> !dreq_q);
   // R7: a halted broadcast keeps the receive status
   p_halt_keeps_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> rxs_q);
   // R1: a data request does not repeat for a single byte
   p_dreq_from_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq_q && dir_q == DIR_RX && !$past(frame_start)) |-> $past(byte_valid));
endmodule

// File: tb/sim_sbrx_top.sv
module sim_sbrx_top;
   localparam int CNT_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             frame_start = 1'b0, frame_bcast = 1'b0, frame_tx = 1'b0;
   logic [CNT_W-1:0] msg_len = '0;
   logic             byte_valid = 1'b0;
   logic [7:0]       byte_data = '0;
   logic             ack_slot = 1'b0, tx_need = 1'b0, host_rd = 1'b0;
   logic             ack_n, irq_data_req, irq_frame_end, irq_comm_err;
   logic             ovr_flag, udr_flag, rx_status;
   logic [7:0]       rd_data;
   logic [CNT_W-1:0] slot_left, msg_left;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sbrx_top u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_bcast(frame_bcast),
      .frame_tx(frame_tx), .msg_len(msg_len), .byte_valid(byte_valid),
      .byte_data(byte_data), .ack_slot(ack_slot), .ack_n(ack_n), .tx_need(tx_need),
      .host_rd(host_rd), .rd_data(rd_data), .irq_data_req(irq_data_req),
      .irq_frame_end(irq_frame_end), .irq_comm_err(irq_comm_err), .ovr_flag(ovr_flag),
      .udr_flag(udr_flag), .rx_status(rx_status), .slot_left(slot_left),
      .msg_left(msg_left)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic start_frame(bit bc, bit tx, int len);
      frame_start = 1'b1; frame_bcast = bc; frame_tx = tx; msg_len = CNT_W'(len);
      tick();
      frame_start = 1'b0;
   endtask

   task automatic put_byte(logic [7:0] d, bit with_rd = 1'b0);
      byte_valid = 1'b1; byte_data = d; host_rd = with_rd;
      tick();
      byte_valid = 1'b0; host_rd = 1'b0;
   endtask

   task automatic host_read();
      host_rd = 1'b1;
      tick();
      host_rd = 1'b0;
   endtask

   task automatic probe_ack(output logic v);
      ack_slot = 1'b1;
      #1 v = ack_n;
      tick();
      ack_slot = 1'b0;
   endtask

   task automatic ask_tx();
      tx_need = 1'b1;
      tick();
      tx_need = 1'b0;
   endtask

   task automatic t_reset();
      chk("R12 ovr", ovr_flag, 0);
      chk("R12 udr", udr_flag, 0);
      chk("R12 rx_status", rx_status, 0);
      chk("R12 irqs", {irq_data_req, irq_frame_end, irq_comm_err}, 0);
      chk("R12 ack_n", ack_n, 0);
      chk("R12 counters", {slot_left, msg_left}, 0);
      chk("R12 rd_data", rd_data, 0);
   endtask

   task automatic t_unicast_basic();
      logic a;
      start_frame(0, 0, 3);
      chk("R5 slot load", slot_left, 32);
      chk("R5 msg load", msg_left, 3);
      chk("R11 rx_status set", rx_status, 1);
      put_byte(8'hA5);
      chk("R1 data", rd_data, 8'hA5);
      chk("R1 dreq pulse", irq_data_req, 1);
      chk("R5 slot dec", slot_left, 31);
      chk("R5 msg dec", msg_left, 2);
      tick();
      chk("R1 dreq single", irq_data_req, 0);
      probe_ack(a);
      chk("R4 ack on accept", a, 0);
      host_read();
   endtask

   task automatic t_unicast_overrun();
      logic a;
      put_byte(8'h3C);          // stored, not read
      put_byte(8'hC3);          // overrun
      chk("R2 ovr set", ovr_flag, 1);
      chk("R2 data kept", rd_data, 8'h3C);
      chk("R2 no dreq", irq_data_req, 0);
      chk("R5 slot moves", slot_left, 29);
      chk("R5 msg held", msg_left, 1);
      chk("R4 ack_n idle", ack_n, 0);
      probe_ack(a);
      chk("R4 nack", a, 1);
      tick();
      chk("R3 ovr held", ovr_flag, 1);
      host_read();
      chk("R3 ovr cleared by read", ovr_flag, 0);
      put_byte(8'hC3);          // retransmission, last message byte
      chk("R1 retransmit stored", rd_data, 8'hC3);
      chk("R6 frame end by msg", irq_frame_end, 1);
      chk("R11 rx_status cleared", rx_status, 0);
      chk("R5 msg zero", msg_left, 0);
      host_read();
   endtask

   task automatic t_same_cycle();
      start_frame(0, 0, 3);
      put_byte(8'h5A);
      put_byte(8'h6B, 1'b1);
      chk("R9 no ovr", ovr_flag, 0);
      chk("R9 stored", rd_data, 8'h6B);
      chk("R9 dreq", irq_data_req, 1);
      host_read();
   endtask

   task automatic t_slot_limit();
      start_frame(0, 0, 5);
      put_byte(8'h01);
      for (int i = 0; i < 31; i++) begin
         put_byte(8'h02);
         if (i == 30) chk("R6 frame end by slots", irq_frame_end, 1);
         else if (i == 15) chk("R6 no early end", irq_frame_end, 0);
      end
      chk("R5 slots used", slot_left, 0);
      chk("R5 msg unchanged", msg_left, 4);
      tick(); tick();
      chk("R3 ovr past frame end", ovr_flag, 1);
      put_byte(8'h77);          // outside the frame
      chk("R6 ignored after end", {irq_data_req, irq_comm_err}, 0);
      chk("R6 data unchanged", rd_data, 8'h01);
      host_read();
      chk("R3 cleared by read", ovr_flag, 0);
   endtask

   task automatic t_broadcast();
      logic a;
      start_frame(1, 0, 4);
      put_byte(8'h11);
      put_byte(8'h22);
      chk("R7 err pulse", irq_comm_err, 1);
      chk("R7 no dreq", irq_data_req, 0);
      chk("R7 data frozen", rd_data, 8'h11);
      chk("R7 ovr", ovr_flag, 1);
      chk("R7 counters", {slot_left, msg_left}, {6'd31, 6'd3});
      probe_ack(a);
      chk("R4 no nack in broadcast", a, 0);
      put_byte(8'h33);
      chk("R7 halted ignore", {irq_data_req, irq_comm_err}, 0);
      chk("R7 counters still", slot_left, 31);
      chk("R7 rx_status held", rx_status, 1);
      host_read();
      chk("R8 ovr kept after read", ovr_flag, 1);
      put_byte(8'h44);
      chk("R8 released", ovr_flag, 0);
      chk("R8 not stored", rd_data, 8'h11);
      chk("R8 no dreq", irq_data_req, 0);
   endtask

   task automatic t_tx_underrun();
      start_frame(0, 0, 3);
      put_byte(8'h90);
      put_byte(8'h91);
      chk("R2 ovr before tx", ovr_flag, 1);
      start_frame(0, 1, 3);
      chk("R11 tx clears rx_status", rx_status, 0);
      ask_tx();
      chk("R10 first dreq", irq_data_req, 1);
      ask_tx();
      chk("R10 no dreq", irq_data_req, 0);
      chk("R10 err", irq_comm_err, 1);
      chk("R10 udr", udr_flag, 1);
      host_read();
      ask_tx();
      chk("R10 dreq after clear", irq_data_req, 1);
      start_frame(0, 0, 2);
      chk("R11 udr cleared", udr_flag, 0);
   endtask

   initial begin
      repeat (3) tick();
      t_reset();
      rst_n = 1'b1;
      tick();
      t_unicast_basic();
      t_unicast_overrun();
      t_same_cycle();
      t_slot_limit();
      t_broadcast();
      t_tx_underrun();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule